// File: doc/BRIEF.md
# Single-to-Half Precision Narrowing Converter

This block takes a 32-bit IEEE binary32 word and produces the 16-bit binary16 word that represents it, under a 3-bit rounding-mode select. The input is rounded first, using the fraction bits that the narrower format drops. The rounded unbiased exponent then places the value in one of four bands: too small (signed zero), half subnormal, half normal, or too large (signed infinity). Inputs whose exponent field is all ones pass through as infinity or NaN.

Rounding is applied only when the input exponent field is neither zero nor all ones. The increment is added at the lowest kept fraction bit of the whole word, so a carry can ripple into the exponent and move the value into the next binade or into overflow. The subnormal band shifts the kept fraction right and truncates, with no second rounding. Overflow always gives infinity, whatever the rounding mode.

The result is registered once. A valid strobe travels alongside the data with one cycle of latency. Reset is synchronous.

Top module: `f32_to_f16_narrow`

## Requirements
- R1: out_valid equals in_valid delayed by one clock, and the result for a word accepted with in_valid high appears on out_word in that same following cycle; a synchronous reset clears out_valid and out_word to zero.
- R2: While in_valid is low, out_word keeps its previous value.
- R3: out_word bit 15 always equals bit 31 of the accepted input, for every band, including zero, infinity and NaN.
- R4: Rounding select encoding: 0 nearest-even, 1 toward zero, 2 toward minus infinity, 3 toward plus infinity, 4 nearest with ties away, which here never increments, as do codes 5 to 7. Taking input bit 13 as the kept LSB, bit 12 as guard, bit 11 as round and bits 10:0 as sticky: code 0 increments when guard is set and any of LSB, round or sticky is set; code 3 increments when any of bits 12:0 is set and bit 31 is 0; code 2 does the same when bit 31 is 1; code 1 never increments.
- R5: The increment is added at bit 13 of the full 32-bit word, so a carry out of the fraction raises the exponent field by one.
- R6: With e the rounded exponent field minus 127, when -14 <= e <= 15 the result is {sign, e+15 in bits 14:10, rounded input bits 22:13 in bits 9:0}.
- R7: When -24 <= e <= -15 the result has exponent field zero and fraction equal to (1024 + rounded bits 22:13) shifted right by (-e-14), truncated.
- R8: When e <= -25, including zero and subnormal binary32 inputs, the result is a zero with the input sign.
- R9: When e >= 16 after rounding, from an input exponent field below 255, the result is infinity (bits 14:10 all ones, bits 9:0 zero) under every rounding mode.
- R10: An input exponent field of 255 gives bits 14:10 all ones; with input bits 22:0 zero the fraction is zero, otherwise the fraction is input bits 22:13 with bit 9 forced to one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is present this cycle |
| in_word | input | 32 | binary32 operand |
| in_rmode | input | 3 | Rounding select |
| out_valid | output | 1 | out_word holds a fresh result |
| out_word | output | 16 | binary16 result |

## Verification
Directed operands sit at both sides of every band edge (e of -25, -24, -15, -14, 15 and 16), each with fraction patterns chosen to be exact, an exact tie with even and odd LSB, just above a tie, and all-ones, under all five rounding codes and both signs; these separate which mode increments and whether a carry moves an operand across a band edge. Hand-worked values pin the tie behaviour, the carry into the next binade, rounding into overflow against truncation below it, and NaN payload forcing. A large random sweep over all 32-bit words and all eight rounding codes is compared with an arithmetic model written from the requirements, and idle cycles between operands show that the output holds.

// File: rtl/f32_to_f16_narrow.sv
module f32_to_f16_narrow #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_word,
  input  logic [2:0]       in_rmode,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_word
);
  localparam int LSB_POS = 13;

  logic        sgn;
  logic [7:0]  bexp;
  logic        is_special, do_round;
  logic        lsb_b, grd_b, rnd_b, stk_b, any_low;
  logic        inc;
  logic [31:0] rounded;
  logic [7:0]  rexp;
  logic [9:0]  rfrac;
  logic signed [9:0] e;
  logic [9:0]  shv;
  logic [9:0]  hexp;
  logic [10:0] sub_frac;
  logic [9:0]  nan_frac;
  logic [15:0] result;

  assign sgn        = in_word[31];
  assign bexp       = in_word[30:23];
  assign is_special = (bexp == 8'hff);
  assign do_round   = (bexp != 8'h00) && !is_special;

  assign lsb_b   = in_word[LSB_POS];
  assign grd_b   = in_word[12];
  assign rnd_b   = in_word[11];
  assign stk_b   = |in_word[10:0];
  assign any_low = |in_word[12:0];

  always_comb begin
    case (in_rmode)
      3'd0:    inc = grd_b & (lsb_b | rnd_b | stk_b);
      3'd2:    inc = any_low & sgn;
      3'd3:    inc = any_low & ~sgn;
      default: inc = 1'b0;
    endcase
  end

  assign rounded  = in_word + {18'd0, (inc & do_round), 13'd0};
  assign rexp     = rounded[30:23];
  assign rfrac    = rounded[22:13];
  assign e        = $signed({2'b00, rexp}) - 10'sd127;
  assign shv      = 10'd0 - e - 10'd14;
  assign hexp     = e + 10'sd15;
  assign sub_frac = {1'b1, rfrac} >> shv[3:0];
  assign nan_frac = (in_word[22:0] != 23'd0) ? (in_word[22:13] | 10'h200) : 10'h000;

  always_comb begin
    if (is_special)
      result = {sgn, 5'h1f, nan_frac};
    else if (e < -10'sd24)
      result = {sgn, 15'd0};
    else if (e < -10'sd14)
      result = {sgn, 5'd0, sub_frac[9:0]};
    else if (e < 10'sd16)
      result = {sgn, hexp[4:0], rfrac};
    else
      result = {sgn, 5'h1f, 10'd0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= result;
    end
  end
endmodule

// File: rtl/f32_to_f16_narrow_chk.sv
module f32_to_f16_narrow_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [31:0] in_word,
  input logic [2:0]  in_rmode,
  input logic        out_valid,
  input logic [15:0] out_word
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_word)); // R2
  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_word[15] == $past(in_word[31])); // R3
  AST_TRUNC_NORMAL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_rmode == 3'd1 && in_word[30:23] >= 8'd113 && in_word[30:23] <= 8'd142)
      |=> out_word[9:0] == $past(in_word[22:13])); // R4
  AST_TINY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_word[30:23] < 8'd102) |=> out_word[14:0] == 15'd0); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_word[30:23] >= 8'd143 && in_word[30:23] != 8'hff)
      |=> out_word[14:0] == 15'h7c00); // R9
  AST_NAN_STAYS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_word[30:23] == 8'hff && in_word[22:0] != 23'd0)
      |=> (out_word[14:10] == 5'h1f && out_word[9])); // R10
endmodule

bind f32_to_f16_narrow f32_to_f16_narrow_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
  .in_rmode(in_rmode), .out_valid(out_valid), .out_word(out_word)
);

// File: tb/sim_f32_to_f16_narrow.sv
`timescale 1ns/1ps
module sim_f32_to_f16_narrow;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic [2:0]  in_rmode = '0;
  logic        out_valid;
  logic [15:0] out_word;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  f32_to_f16_narrow u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .in_rmode(in_rmode), .out_valid(out_valid), .out_word(out_word)
  );

  function automatic logic [15:0] model(logic [31:0] x, logic [2:0] rm);
    int unsigned bexp, mant, low, comb, f10, inc;
    int e;
    logic s;
    logic [15:0] r;
    s = x[31];
    bexp = int'(x[30:23]);
    mant = int'(x[22:0]);
    if (bexp == 255) begin
      f10 = (mant == 0) ? 0 : ((mant / 8192) | 512);
      r = {s, 5'h1f, 10'(f10)};
      return r;
    end
    inc = 0;
    low = mant % 8192;
    if (bexp != 0) begin
      case (rm)
        3'd0: inc = (low > 4096 || (low == 4096 && ((mant / 8192) % 2) == 1)) ? 1 : 0;
        3'd2: inc = (low != 0 && s) ? 1 : 0;
        3'd3: inc = (low != 0 && !s) ? 1 : 0;
        default: inc = 0;
      endcase
    end
    comb = bexp * 8388608 + mant + inc * 8192;
    bexp = comb / 8388608;
    mant = comb % 8388608;
    f10 = mant / 8192;
    e = int'(bexp) - 127;
    if (e < -24) r = {s, 15'd0};
    else if (e < -14) r = {s, 5'd0, 10'((f10 + 1024) / (1 << (-e - 14)))};
    else if (e < 16) r = {s, 5'(e + 15), 10'(f10)};
    else r = {s, 15'h7c00};
    return r;
  endfunction

  function automatic string tag_of(logic [31:0] x);
    int e;
    e = int'(x[30:23]) - 127;
    if (x[30:23] == 8'hff) return "R10";
    if (e < -24) return "R8";
    if (e < -14) return "R7";
    if (e < 16) return "R6";
    return "R9";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] x, logic [2:0] rm, string tag, bit use_tag);
    logic [15:0] exp_w;
    string t;
    exp_w = model(x, rm);
    t = use_tag ? tag : tag_of(x);
    @(negedge clk);
    in_valid = 1'b1; in_word = x; in_rmode = rm;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1", {31'd0, out_valid}, 32'd1);
    check(t, {16'd0, out_word}, {16'd0, exp_w});
    check("R3", {31'd0, out_word[15]}, {31'd0, x[31]});
  endtask

  task automatic expect_val(logic [31:0] x, logic [2:0] rm, logic [15:0] want, string tag);
    @(negedge clk);
    in_valid = 1'b1; in_word = x; in_rmode = rm;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, {16'd0, out_word}, {16'd0, want});
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int ebound[6] = '{-25, -24, -15, -14, 15, 16};
    logic [22:0] fpat[8] = '{23'h000000, 23'h001000, 23'h003000, 23'h001001,
                             23'h7fffff, 23'h7ff000, 23'h400800, 23'h000fff};
    repeat (3) @(negedge clk);
    check("R1", {31'd0, out_valid}, 32'd0);
    check("R1", {16'd0, out_word}, 32'd0);
    rst = 1'b0;

    // R4 hand-worked ties and directions
    expect_val(32'h3F801000, 3'd0, 16'h3C00, "R4");
    expect_val(32'h3F803000, 3'd0, 16'h3C02, "R4");
    expect_val(32'h3F801000, 3'd3, 16'h3C01, "R4");
    expect_val(32'h3F801000, 3'd2, 16'h3C00, "R4");
    expect_val(32'hBF801000, 3'd2, 16'hBC01, "R4");
    expect_val(32'hBF801000, 3'd3, 16'hBC00, "R4");
    expect_val(32'h3F801000, 3'd4, 16'h3C00, "R4");
    expect_val(32'h3F801FFF, 3'd1, 16'h3C00, "R4");
    expect_val(32'h3F801FFF, 3'd6, 16'h3C00, "R4");
    // R5 carry into exponent
    expect_val(32'h3FFFF000, 3'd0, 16'h4000, "R5");
    expect_val(32'h477FF000, 3'd0, 16'h7C00, "R5");
    expect_val(32'h477FF000, 3'd1, 16'h7BFF, "R5");
    // R6..R10 spot values
    expect_val(32'h3F800000, 3'd0, 16'h3C00, "R6");
    expect_val(32'h38000000, 3'd0, 16'h0200, "R7");
    expect_val(32'h33800000, 3'd0, 16'h0001, "R7");
    expect_val(32'h33000000, 3'd3, 16'h0000, "R8");
    expect_val(32'h80000000, 3'd0, 16'h8000, "R8");
    expect_val(32'h7F7FFFFF, 3'd1, 16'h7C00, "R9");
    expect_val(32'hFF7FFFFF, 3'd3, 16'hFC00, "R9");
    expect_val(32'h7F800000, 3'd0, 16'h7C00, "R10");
    expect_val(32'h7F800001, 3'd0, 16'h7E00, "R10");
    expect_val(32'hFFC00000, 3'd0, 16'hFE00, "R10");

    // R2 hold while idle
    repeat (3) @(negedge clk);
    in_word = 32'h3F800000;
    @(negedge clk);
    check("R2", {16'd0, out_word}, 32'h0000FE00);
    check("R1", {31'd0, out_valid}, 32'd0);

    // band-edge sweep
    for (int bi = 0; bi < 6; bi++)
      for (int fi = 0; fi < 8; fi++)
        for (int m = 0; m < 5; m++)
          for (int sg = 0; sg < 2; sg++)
            apply({sg[0], 8'(ebound[bi] + 127), fpat[fi]}, 3'(m), "", 1'b0);

    // random sweep
    for (int k = 0; k < 20000; k++)
      apply($urandom, 3'($urandom_range(0, 7)), "R4", 1'b1);

    // reset clears
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", {15'd0, out_valid, out_word}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule